// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It sits in front of a 256-byte storage array and never generates the bus clock. The bus lines arrive as plain inputs and are oversampled on a fast system clock. The block drives the data line only through an active-high pull-low enable, which an open-drain pad turns into a wired-AND with the master.

A master opens a transfer with a start condition and then sends a device byte. This byte carries a fixed type code, three select bits and a direction bit. A write command carries a word address and then data bytes, which collect in a 16-byte page buffer. A stop ends the write and launches a timed programming cycle. While that cycle runs, the bus is ignored; at its end the buffered bytes land in the array.

A read returns bytes from the current word address, most significant bit first. The address advances after every byte. A random read combines a word-address write, a repeated start and a read command. A master NoAck followed by a stop returns the block to standby.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset sda_pull_o is low and every one of the 256 bytes reads back as 0x00.
- R2: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop; from standby, a byte clocked in without a preceding start receives no acknowledge.
- R3: The device byte is sent MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal dev_sel_i. Bit 0 selects read (1) or write (0). The block acknowledges (sda_pull_o high across the 9th SCL high phase) only when both fields match.
- R4: The word address and every data byte of a write are acknowledged on the 9th clock. sda_pull_o only ever rises in response to an SCL falling edge, so the block moves SDA only while SCL is low.
- R5: A stop received after at least one complete data byte starts a programming cycle lasting exactly WRITE_CLKS system clocks. After the cycle, the written bytes read back.
- R6: While the programming cycle runs, start conditions are ignored. A start followed by a matching device byte gets no acknowledge.
- R7: Writes stay within a page of PAGE_BYTES (16) bytes. Word address bits 7:4 stay fixed while bits 3:0 advance and wrap from 0xF to 0x0.
- R8: A read shifts out the byte at the current word address, MSB first. The address advances by one after each byte sent and wraps from 0xFF to 0x00.
- R9: After a master NoAck and a stop, SDA is released and the block is in standby. A following current-address read returns the byte after the last one sent.
- R10: A stop that follows only the word address (no data byte) starts no programming cycle. A device byte sent immediately afterwards is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| dev_sel_i | input | 3 | Strap value compared with device byte bits 3:1 |
| sda_pull_o | output | 1 | High to pull the data line low |

## Verification
Each bus pin passes through two synchroniser flops and one edge register before the control state updates. The pull enable therefore changes three system clocks after the SCL edge that causes it. The bench holds every SCL phase for ten clocks and samples acknowledge and read bits five clocks into the high phase, well past that latency and well before the next edge. A programming cycle starts about three clocks after the stop's SDA rise and lasts WRITE_CLKS clocks. The bench probes the bus twenty clocks after the stop to see it ignored, and reads data back only after WRITE_CLKS plus a margin.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADDR, S_ADDR_ACK,
        S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_WAIT, S_PROG
    } eep_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [1:0] scl_pipe;
        logic [1:0] sda_pipe;
        logic       scl_last;
        logic       sda_last;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[0], sda_i};
        sync_d.scl_last = sync_q.scl_pipe[1];
        sync_d.sda_last = sync_q.sda_pipe[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s    = sync_q.scl_pipe[1];
    assign sda_s    = sync_q.sda_pipe[1];
    assign scl_rise = scl_s & ~sync_q.scl_last;
    assign scl_fall = ~scl_s & sync_q.scl_last;
    // SDA moving while SCL stays high marks a bus condition, not data
    assign start_ev = scl_s & sync_q.scl_last & sync_q.sda_last & ~sda_s;
    assign stop_ev  = scl_s & sync_q.scl_last & ~sync_q.sda_last & sda_s;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done_o = tmr_q.run && (tmr_q.cnt == CW'(CYCLES - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (done_o) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
    output logic [7:0]                    rd_data,
    input  logic                          commit,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_idx,
    input  logic [PAGE_BYTES-1:0][7:0]    pbuf,
    input  logic [PAGE_BYTES-1:0]         mask
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0] mem_q [MEM_BYTES];

    assign rd_data = mem_q[rd_addr];

    // all buffered slots of the page land in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_BYTES; a++) mem_q[a] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem_q[{page_idx, PW'(i)}] <= pbuf[i];
            end
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int WRITE_CLKS = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_pull_o
);
    import eep_pkg::*;

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int GW = AW - PW;

    typedef struct packed {
        eep_state_e                st;
        logic [3:0]                cnt;
        logic [7:0]                sh;
        logic [AW-1:0]             ptr;
        logic                      rw;
        logic                      pull;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
        logic [PAGE_BYTES-1:0]     mask;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    eep_state_e st_w;
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       prog_start, prog_done, commit;
    logic [7:0] rd_data;

    eep_bus_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_prog_timer #(.CYCLES(WRITE_CLKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .done_o  (prog_done)
    );

    eep_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (ctl_q.ptr),
        .rd_data  (rd_data),
        .commit   (commit),
        .page_idx (ctl_q.ptr[AW-1:PW]),
        .pbuf     (ctl_q.pbuf),
        .mask     (ctl_q.mask)
    );

    always_comb begin
        ctl_d      = ctl_q;
        prog_start = 1'b0;
        commit     = 1'b0;

        if (ctl_q.st == S_PROG) begin
            // bus is deaf until the array has been updated
            if (prog_done) begin
                commit     = 1'b1;
                ctl_d.st   = S_IDLE;
                ctl_d.mask = '0;
            end
        end else if (start_ev) begin
            ctl_d.st   = S_DEV;
            ctl_d.cnt  = '0;
            ctl_d.pull = 1'b0;
        end else if (stop_ev) begin
            ctl_d.cnt  = '0;
            ctl_d.pull = 1'b0;
            if (ctl_q.st == S_WDATA && |ctl_q.mask) begin
                ctl_d.st   = S_PROG;
                prog_start = 1'b1;
            end else begin
                ctl_d.st = S_IDLE;
            end
        end else begin
            unique case (ctl_q.st)
                S_DEV, S_ADDR, S_WDATA: begin
                    if (scl_rise && ctl_q.cnt < 4'(BYTE_BITS)) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'(BYTE_BITS)) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.st == S_DEV) begin
                            if (ctl_q.sh[7:4] == DEV_TYPE && ctl_q.sh[3:1] == dev_sel_i) begin
                                ctl_d.st   = S_DEV_ACK;
                                ctl_d.rw   = ctl_q.sh[0];
                                ctl_d.pull = 1'b1;
                            end else begin
                                ctl_d.st = S_WAIT;
                            end
                        end else if (ctl_q.st == S_ADDR) begin
                            ctl_d.ptr  = ctl_q.sh[AW-1:0];
                            ctl_d.mask = '0;
                            ctl_d.st   = S_ADDR_ACK;
                            ctl_d.pull = 1'b1;
                        end else begin
                            ctl_d.pbuf[ctl_q.ptr[PW-1:0]] = ctl_q.sh;
                            ctl_d.mask[ctl_q.ptr[PW-1:0]] = 1'b1;
                            ctl_d.ptr  = {ctl_q.ptr[AW-1:PW], ctl_q.ptr[PW-1:0] + 1'b1};
                            ctl_d.st   = S_WDATA_ACK;
                            ctl_d.pull = 1'b1;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        if (ctl_q.rw) begin
                            ctl_d.st   = S_RDATA;
                            ctl_d.sh   = rd_data;
                            ctl_d.pull = ~rd_data[7];
                        end else begin
                            ctl_d.st   = S_ADDR;
                            ctl_d.pull = 1'b0;
                        end
                    end
                end
                S_ADDR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        ctl_d.st   = S_WDATA;
                        ctl_d.pull = 1'b0;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 4'(BYTE_BITS - 1)) begin
                            ctl_d.st   = S_RACK;
                            ctl_d.cnt  = '0;
                            ctl_d.pull = 1'b0;
                        end else begin
                            ctl_d.cnt  = ctl_q.cnt + 4'd1;
                            ctl_d.sh   = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.pull = ~ctl_q.sh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        ctl_d.ptr = ctl_q.ptr + 1'b1;
                        if (sda_s) ctl_d.st  = S_WAIT;
                        else       ctl_d.cnt = 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd1) begin
                        ctl_d.st   = S_RDATA;
                        ctl_d.cnt  = '0;
                        ctl_d.sh   = rd_data;
                        ctl_d.pull = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull_o = ctl_q.pull;
    assign st_w       = ctl_q.st;

    // page index width is used only by the array port
    if (GW < 1) begin : g_bad_cfg
        initial $error("MEM_BYTES must exceed PAGE_BYTES");
    end
endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
#(
    parameter int WRITE_CLKS = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_o,
    input logic       scl_fall,
    input eep_state_e st
);
    logic in_prog;
    int   prog_cnt;

    assign in_prog = (st == S_PROG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prog_cnt <= 0;
        else if (in_prog) prog_cnt <= prog_cnt + 1;
        else              prog_cnt <= 0;
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sda_pull_o);

    a_r6_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog |-> !sda_pull_o);

    a_r9_rack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RACK) |-> !sda_pull_o);

    a_r4_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    a_r5_prog_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_prog) |-> (prog_cnt == WRITE_CLKS));
endmodule

bind eeprom_i2c_slave eep_checker #(.WRITE_CLKS(WRITE_CLKS)) i_eep_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .scl_fall   (scl_fall),
    .st         (st_w)
);

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
    localparam int         WR_CLKS = 400;
    localparam logic [2:0] SEL     = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_pull, sda_line;
    int   checks = 0, errors = 0;
    logic [7:0] model [256];

    assign sda_line = sda_m & ~sda_pull;
    always #2.5 clk = ~clk;

    eeprom_i2c_slave #(.WRITE_CLKS(WR_CLKS)) i_eeprom_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .dev_sel_i(SEL), .sda_pull_o(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(10); scl = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(10); scl = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(10); scl = 1'b1; tick(10); scl = 1'b0; tick(10);
        end
        sda_m = 1'b1; tick(10); scl = 1'b1; tick(5);
        ack = ~sda_line; tick(5); scl = 1'b0; tick(10);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(10); scl = 1'b1; tick(5); b[i] = sda_line; tick(5); scl = 1'b0;
        end
        tick(5); sda_m = ~give_ack; tick(5); scl = 1'b1; tick(10); scl = 1'b0;
        tick(5); sda_m = 1'b1; tick(5);
    endtask

    function automatic logic [7:0] devb(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    // write n bytes from addr, wrapping inside the 16-byte page, then stop
    task automatic write_page(input logic [7:0] addr, input int n, input logic [7:0] seed, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(devb(SEL, 1'b0), ack); check({req, " dev ack"}, ack, 1);
        send_byte(addr, ack);            check("R4 addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 13);
            send_byte(d, ack); check("R4 data ack", ack, 1);
            model[{addr[7:4], 4'(addr[3:0] + 4'(k))}] = d;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] addr, input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(devb(SEL, 1'b0), ack); check({req, " rd dev-w ack"}, ack, 1);
        send_byte(addr, ack);            check({req, " rd addr ack"}, ack, 1);
        bus_start();
        send_byte(devb(SEL, 1'b1), ack); check({req, " rd dev-r ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            check({req, " read data"}, b, model[8'(addr + 8'(k))]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        for (int a = 0; a < 256; a++) model[a] = 8'h00;
        tick(10);
        check("R1 pull in reset", sda_pull, 0);
        rst_n = 1'b1; tick(10);
        check("R1 pull after reset", sda_pull, 0);

        // R2: no start seen yet
        send_byte(devb(SEL, 1'b0), ack); check("R2 no ack without start", ack, 0);
        bus_stop();

        read_seq(8'h00, 2, "R1");

        // R3: sweep every select value, and a wrong type code
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte(devb(3'(s), 1'b0), ack);
            check("R3 select match", ack, (3'(s) == SEL) ? 1 : 0);
            bus_stop();
        end
        bus_start();
        send_byte({4'b1011, SEL, 1'b0}, ack); check("R3 type code", ack, 0);
        bus_stop();

        // R5 and R6: page write, bus ignored during the cycle
        write_page(8'h20, 4, 8'h11, "R5");
        tick(20);
        bus_start();
        send_byte(devb(SEL, 1'b0), ack); check("R6 ignored while writing", ack, 0);
        bus_stop();
        tick(WR_CLKS + 20);
        read_seq(8'h20, 4, "R5");

        // R7: page wrap
        write_page(8'h3C, 6, 8'h80, "R7");
        tick(WR_CLKS + 20);
        read_seq(8'h30, 16, "R7");

        // R8: address wrap at the top of the array
        write_page(8'hFE, 2, 8'hC3, "R8");
        tick(WR_CLKS + 20);
        read_seq(8'hFF, 3, "R8");

        // R9: NoAck + stop, then current-address read
        read_seq(8'h21, 1, "R9");
        check("R9 released after stop", sda_pull, 0);
        bus_start();
        send_byte(devb(SEL, 1'b1), ack); check("R9 current read ack", ack, 1);
        recv_byte(b, 1'b0);
        check("R9 current read data", b, model[8'h22]);
        bus_stop();

        // R10: address-only write starts no cycle
        bus_start();
        send_byte(devb(SEL, 1'b0), ack); check("R10 dev ack", ack, 1);
        send_byte(8'h50, ack);           check("R10 addr ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(devb(SEL, 1'b0), ack); check("R10 no write cycle", ack, 1);
        bus_stop();

        // R8 sweep: four full pages written then read back in one pass
        for (int p = 4; p < 8; p++) begin
            write_page(8'(p * 16), 16, 8'(p * 7 + 3), "R8");
            tick(WR_CLKS + 20);
        end
        read_seq(8'h40, 64, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule